// File: doc/BRIEF.md
# Flash Block Guard: Block Decoder with Boot-Sector Write Protection

This block sits between the command logic of a boot-sector flash array and its program/erase engine. It turns an incoming address, given as a word address plus an optional byte-select bit, into the number, base and size of the erasable block that holds it. It also reports the offset of the address inside that block. The array holds one mebibyte in eleven blocks: a 16 KiB boot block, two 8 KiB parameter blocks, one 96 KiB main block and seven 128 KiB main blocks. A build parameter places the boot block at the bottom or at the top of the address space. Placing it at the top mirrors the whole layout.

When a program or erase request arrives, the block decides whether it may go ahead. Every operation needs a valid programming supply. The boot block also needs one of two unlock paths: the high-voltage flag on the reset pin, or a HIGH level on the write-protect input. A second build parameter models a package without a write-protect pin, and in that case the input is ignored. A granted operation stays active until the engine signals completion. While it is active, the supply is watched, and for a boot-block operation the unlock condition is watched as well. If a watched condition drops, the operation is aborted. A denied request produces a one-cycle error pulse with cause flags for the status register.

The request, completion and decision signals are single-cycle control pulses with no back-pressure. A request is taken only when no operation is active; the block holds no queue. Requests that arrive while an operation is active are dropped without any response, so the sender must wait for the operation to end before issuing the next one.

Top module: `flash_block_guard`

## Requirements
- R1: With the boot block at the bottom, blocks are numbered upward from byte address 0. Index 0 is the 16 KiB boot block at 0x00000. Indices 1 and 2 are the 8 KiB blocks at 0x04000 and 0x06000. Index 3 is the 96 KiB block at 0x08000. Indices 4 to 10 are 128 KiB blocks at 0x20000 × (index − 3). The index, base and size outputs are combinational, and the offset output equals the address minus the base.
- R2: With TOP_BOOT = 1 the layout is mirrored, and each index counts downward from address 0xFFFFF. Index 0 is the boot block at 0xFC000, indices 1 and 2 are at 0xFA000 and 0xF8000, index 3 is at 0xE0000, and index k (4 to 10) is at 0x20000 × (10 − k).
- R3: When byte_mode = 1 the byte address is {word_addr, byte_lsb}. When byte_mode = 0 it is {word_addr, 0}, and byte_lsb has no effect.
- R4: A request taken without vpp_ok is denied. One cycle after the request edge, err_pulse and err_vpp are 1 and permit is 0. err_prog is 1 for a program request (req_erase = 0), and err_erase is 1 for an erase request (req_erase = 1).
- R5: A request on the boot block with vpp_ok is granted if hv_unlock or wp_pin is 1. Otherwise it is denied, with err_pulse and the program or erase flag set and err_vpp = 0.
- R6: A request on any non-boot block with vpp_ok is granted regardless of wp_pin and hv_unlock. The grant appears as permit = 1 for one cycle and op_active = 1 from the same cycle.
- R7: With HAS_WP = 0, wp_pin is ignored, so only hv_unlock unlocks the boot block.
- R8: While op_active = 1 and op_done = 0, losing vpp_ok aborts the operation. For a boot-block operation, losing both unlock paths also aborts it. An abort gives a one-cycle abort_pulse in the following cycle, and op_active clears in that same cycle.
- R9: op_done clears op_active at the next edge without an abort. A request that arrives while op_active = 1 is ignored: it gives no permit and no error flags, and the operation stays active.
- R10: After reset all pulse and flag outputs and op_active are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_addr | input | 19 | Word address |
| byte_lsb | input | 1 | Byte select, used in byte mode |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| wp_pin | input | 1 | Write-protect input, HIGH unlocks the boot block |
| hv_unlock | input | 1 | High-voltage level present on the reset pin |
| vpp_ok | input | 1 | Programming supply valid |
| req_valid | input | 1 | Program/erase request pulse |
| req_erase | input | 1 | 1 = erase, 0 = program |
| op_done | input | 1 | Engine reports the active operation finished |
| blk_idx | output | 4 | Block index of the current address |
| blk_base | output | 20 | Byte base address of that block |
| blk_size | output | 20 | Block size in bytes |
| blk_offset | output | 20 | Byte offset inside the block |
| blk_is_boot | output | 1 | Current address lies in the boot block |
| permit | output | 1 | Request granted (one cycle) |
| err_pulse | output | 1 | Request denied (one cycle) |
| err_prog | output | 1 | Denied request was a program |
| err_erase | output | 1 | Denied request was an erase |
| err_vpp | output | 1 | Denial involved a missing supply |
| abort_pulse | output | 1 | Active operation aborted (one cycle) |
| op_active | output | 1 | A granted operation is in progress |

## Verification
The decoder is swept over every 4 KiB page in both layouts. Each page is probed at its first and last byte, so an off-by-one in a boundary compare or in the mirroring arithmetic shows up as a wrong index, base or offset. Word-mode and byte-mode probes at odd addresses show whether the byte-select bit reaches the offset only in byte mode.

The decision logic is tried on boot, parameter and main addresses with all eight combinations of write-protect, high-voltage unlock and supply, for both program and erase. Because the two instances differ in boot placement and write-protect presence, the same address and flags give different expected outcomes, which separates the unlock paths from the supply rule.

Timed scenarios then drop each watched condition during an operation. They show that only boot operations watch the unlock, that any operation watches the supply, and that requests made while busy are ignored.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;
  localparam int ADDR_W      = 20;                 // byte address width
  localparam int WORD_W      = ADDR_W - 1;         // word address width
  localparam int BLOCKS      = 11;
  localparam int IDX_W       = $clog2(BLOCKS);
  localparam int BOOT_BYTES  = 1 << 14;
  localparam int PARAM_BYTES = 1 << 13;
  localparam int MAIN0_BYTES = 3 << 15;
  localparam int MAIN_BYTES  = 1 << 17;
  localparam int MAIN_SH     = $clog2(MAIN_BYTES);
  localparam int BOOT_IDX    = 0;
  localparam int FIRST_MAIN  = 3;                  // index of the short main block

  typedef struct packed {
    logic             erase;
    logic             boot;
  } op_req_t;
endpackage

// File: rtl/fbg_map.sv
`timescale 1ns/1ps
module fbg_map
  import fbg_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] size,
  output logic [ADDR_W-1:0] offset
);
  // Cumulative ends of the small blocks in the bottom-boot view
  localparam logic [ADDR_W-1:0] END_BOOT = ADDR_W'(BOOT_BYTES);
  localparam logic [ADDR_W-1:0] END_P0   = END_BOOT + ADDR_W'(PARAM_BYTES);
  localparam logic [ADDR_W-1:0] END_P1   = END_P0 + ADDR_W'(PARAM_BYTES);
  localparam logic [ADDR_W-1:0] END_M0   = END_P1 + ADDR_W'(MAIN0_BYTES);

  logic [ADDR_W-1:0] mapped;   // address as seen in the bottom-boot view
  logic [ADDR_W-1:0] low_base; // base in the bottom-boot view

  generate
    if (TOP_BOOT) begin : g_top
      // mirroring: address a maps to ~a, a block [b, b+s) maps to [-(b+s), -b)
      assign mapped = ~addr;
      assign base   = ADDR_W'(0) - low_base - size;
    end else begin : g_bottom
      assign mapped = addr;
      assign base   = low_base;
    end
  endgenerate

  always_comb begin
    if (mapped < END_BOOT) begin
      idx      = IDX_W'(BOOT_IDX);
      low_base = '0;
      size     = ADDR_W'(BOOT_BYTES);
    end else if (mapped < END_P0) begin
      idx      = IDX_W'(BOOT_IDX + 1);
      low_base = END_BOOT;
      size     = ADDR_W'(PARAM_BYTES);
    end else if (mapped < END_P1) begin
      idx      = IDX_W'(BOOT_IDX + 2);
      low_base = END_P0;
      size     = ADDR_W'(PARAM_BYTES);
    end else if (mapped < END_M0) begin
      idx      = IDX_W'(FIRST_MAIN);
      low_base = END_P1;
      size     = ADDR_W'(MAIN0_BYTES);
    end else begin
      // full-size main blocks sit on natural 128 KiB boundaries
      idx      = IDX_W'(FIRST_MAIN) + IDX_W'(mapped[ADDR_W-1:MAIN_SH]);
      low_base = ADDR_W'(mapped[ADDR_W-1:MAIN_SH]) << MAIN_SH;
      size     = ADDR_W'(MAIN_BYTES);
    end
  end

  assign offset = addr - base;
endmodule

// File: rtl/fbg_gate.sv
`timescale 1ns/1ps
module fbg_gate
  import fbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_erase,
  input  logic is_boot,
  input  logic vpp_ok,
  input  logic unlock,
  input  logic busy,
  output logic start,
  output logic permit,
  output logic err_pulse,
  output logic err_prog,
  output logic err_erase,
  output logic err_vpp
);
  logic    taken;
  logic    allowed;
  op_req_t rq;

  assign rq      = '{erase: req_erase, boot: is_boot};
  assign taken   = req_valid && !busy;
  assign allowed = vpp_ok && (!rq.boot || unlock);
  assign start   = taken && allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      permit    <= 1'b0;
      err_pulse <= 1'b0;
      err_prog  <= 1'b0;
      err_erase <= 1'b0;
      err_vpp   <= 1'b0;
    end else begin
      permit    <= start;
      err_pulse <= taken && !allowed;
      err_prog  <= taken && !allowed && !rq.erase;
      err_erase <= taken && !allowed && rq.erase;
      err_vpp   <= taken && !vpp_ok;
    end
  end

  a_r4_grant_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> $past(vpp_ok));
  a_r4_supply_flag_is_denial: assert property (@(posedge clk) disable iff (!rst_n)
    err_vpp |-> (err_pulse && !permit));
  a_r5_boot_grant_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && $past(is_boot)) |-> $past(unlock));
  a_r4_one_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $onehot({err_prog, err_erase}));
  a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(req_valid)) |-> !(permit || err_pulse));
endmodule

// File: rtl/fbg_track.sv
`timescale 1ns/1ps
module fbg_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_boot,
  input  logic op_done,
  input  logic vpp_ok,
  input  logic unlock,
  output logic op_active,
  output logic abort_pulse
);
  logic op_boot;
  logic lost;

  // completion takes precedence over a same-cycle condition loss
  assign lost = op_active && !op_done && (!vpp_ok || (op_boot && !unlock));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_active   <= 1'b0;
      op_boot     <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= lost;
      if (start) begin
        op_active <= 1'b1;
        op_boot   <= start_boot;
      end else if (op_done || lost) begin
        op_active <= 1'b0;
        op_boot   <= 1'b0;
      end
    end
  end

  a_r8_abort_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> ($past(op_active) && !op_active));
  a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && op_done) |=> (!op_active && !abort_pulse));
  a_r8_supply_watched: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && !op_done && !vpp_ok) |=> abort_pulse);
endmodule

// File: rtl/flash_block_guard.sv
`timescale 1ns/1ps
module flash_block_guard
  import fbg_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0,
  parameter bit HAS_WP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_addr,
  input  logic              byte_lsb,
  input  logic              byte_mode,
  input  logic              wp_pin,
  input  logic              hv_unlock,
  input  logic              vpp_ok,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic              op_done,
  output logic [IDX_W-1:0]  blk_idx,
  output logic [ADDR_W-1:0] blk_base,
  output logic [ADDR_W-1:0] blk_size,
  output logic [ADDR_W-1:0] blk_offset,
  output logic              blk_is_boot,
  output logic              permit,
  output logic              err_pulse,
  output logic              err_prog,
  output logic              err_erase,
  output logic              err_vpp,
  output logic              abort_pulse,
  output logic              op_active
);
  logic [ADDR_W-1:0] byte_addr;
  logic              unlock;
  logic              start;

  assign byte_addr = byte_mode ? {word_addr, byte_lsb} : {word_addr, 1'b0};

  generate
    if (HAS_WP) begin : g_wp
      assign unlock = hv_unlock || wp_pin;
    end else begin : g_no_wp
      assign unlock = hv_unlock;
    end
  endgenerate

  fbg_map #(.TOP_BOOT(TOP_BOOT)) u_map (
    .addr   (byte_addr),
    .idx    (blk_idx),
    .base   (blk_base),
    .size   (blk_size),
    .offset (blk_offset)
  );

  assign blk_is_boot = (blk_idx == IDX_W'(BOOT_IDX));

  fbg_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_erase (req_erase),
    .is_boot   (blk_is_boot),
    .vpp_ok    (vpp_ok),
    .unlock    (unlock),
    .busy      (op_active),
    .start     (start),
    .permit    (permit),
    .err_pulse (err_pulse),
    .err_prog  (err_prog),
    .err_erase (err_erase),
    .err_vpp   (err_vpp)
  );

  fbg_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_boot  (blk_is_boot),
    .op_done     (op_done),
    .vpp_ok      (vpp_ok),
    .unlock      (unlock),
    .op_active   (op_active),
    .abort_pulse (abort_pulse)
  );

  a_r1_offset_inside: assert property (@(posedge clk) disable iff (!rst_n)
    blk_offset < blk_size);
  a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    blk_idx < IDX_W'(BLOCKS));
  a_r6_grant_starts_op: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> op_active);

  generate
    if (!HAS_WP) begin : g_chk_no_wp
      a_r7_only_hv_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && $past(blk_is_boot)) |-> $past(hv_unlock));
    end
  endgenerate
endmodule

// File: tb/test_flash_block_guard.sv
`timescale 1ns/1ps
module test_flash_block_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [18:0] word_addr = '0;
  logic byte_lsb = 1'b0, byte_mode = 1'b1, wp_pin = 1'b0, hv_unlock = 1'b0;
  logic vpp_ok = 1'b0, req_valid = 1'b0, req_erase = 1'b0, op_done = 1'b0;

  logic [3:0]  a_idx, b_idx;
  logic [19:0] a_base, a_size, a_off, b_base, b_size, b_off;
  logic a_boot, a_perm, a_err, a_ep, a_ee, a_ev, a_abort, a_act;
  logic b_boot, b_perm, b_err, b_ep, b_ee, b_ev, b_abort, b_act;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk; // 125 MHz

  // bottom boot, write-protect pin present
  flash_block_guard #(.TOP_BOOT(1'b0), .HAS_WP(1'b1)) i_flash_block_guard (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .byte_lsb(byte_lsb),
    .byte_mode(byte_mode), .wp_pin(wp_pin), .hv_unlock(hv_unlock), .vpp_ok(vpp_ok),
    .req_valid(req_valid), .req_erase(req_erase), .op_done(op_done),
    .blk_idx(a_idx), .blk_base(a_base), .blk_size(a_size), .blk_offset(a_off),
    .blk_is_boot(a_boot), .permit(a_perm), .err_pulse(a_err), .err_prog(a_ep),
    .err_erase(a_ee), .err_vpp(a_ev), .abort_pulse(a_abort), .op_active(a_act));

  // top boot, no write-protect pin
  flash_block_guard #(.TOP_BOOT(1'b1), .HAS_WP(1'b0)) i_flash_block_guard_top (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .byte_lsb(byte_lsb),
    .byte_mode(byte_mode), .wp_pin(wp_pin), .hv_unlock(hv_unlock), .vpp_ok(vpp_ok),
    .req_valid(req_valid), .req_erase(req_erase), .op_done(op_done),
    .blk_idx(b_idx), .blk_base(b_base), .blk_size(b_size), .blk_offset(b_off),
    .blk_is_boot(b_boot), .permit(b_perm), .err_pulse(b_err), .err_prog(b_ep),
    .err_erase(b_ee), .err_vpp(b_ev), .abort_pulse(b_abort), .op_active(b_act));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int blk_bytes(input int i);
    if (i == 0) return 16384;
    if (i < 3) return 8192;
    if (i == 3) return 98304;
    return 131072;
  endfunction

  // reference decode from the size list, walking away from the boot end
  function automatic void ref_map(input bit top, input int a,
                                  output int idx, output int base, output int size);
    int cum = 0;
    idx = -1; base = 0; size = 0;
    for (int i = 0; i < 11; i++) begin
      int s = blk_bytes(i);
      int b = top ? (1048576 - cum - s) : cum;
      if (a >= b && a < b + s) begin
        idx = i; base = b; size = s;
      end
      cum += s;
    end
  endfunction

  task automatic check_map(input string tag, input int a);
    int ia, ba, sa, ib, bb, sb;
    ref_map(1'b0, a, ia, ba, sa);
    ref_map(1'b1, a, ib, bb, sb);
    chk({tag, " bottom"}, {a_idx, a_base, a_size, a_off, a_boot},
        {4'(ia), 20'(ba), 20'(sa), 20'(a - ba), ia == 0});
    chk({tag, " top"}, {b_idx, b_base, b_size, b_off, b_boot},
        {4'(ib), 20'(bb), 20'(sb), 20'(a - bb), ib == 0});
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one request on both instances, then complete any granted op
  task automatic req_chk(input int a, input bit er, input bit wp, input bit hv, input bit vp);
    int ia, ba, sa, ib, bb, sb;
    bit ok_a, ok_b;
    string ta, tb;
    ref_map(1'b0, a, ia, ba, sa);
    ref_map(1'b1, a, ib, bb, sb);
    @(negedge clk);
    word_addr = 19'(a >> 1); byte_lsb = a[0]; byte_mode = 1'b1;
    wp_pin = wp; hv_unlock = hv; vpp_ok = vp; req_erase = er; req_valid = 1'b1;
    ok_a = vp && (ia != 0 || hv || wp);
    ok_b = vp && (ib != 0 || hv);
    ta = !vp ? "R4" : (ia == 0 ? "R5" : "R6");
    tb = !vp ? "R4" : (ib == 0 ? "R7" : "R6");
    tick();
    chk($sformatf("%s bottom req a=%0h er=%0d wp=%0d hv=%0d vpp=%0d", ta, a, er, wp, hv, vp),
        {a_perm, a_err, a_ep, a_ee, a_ev, a_act},
        {ok_a, !ok_a, !ok_a && !er, !ok_a && er, !vp, ok_a});
    chk($sformatf("%s top req a=%0h er=%0d wp=%0d hv=%0d vpp=%0d", tb, a, er, wp, hv, vp),
        {b_perm, b_err, b_ep, b_ee, b_ev, b_act},
        {ok_b, !ok_b, !ok_b && !er, !ok_b && er, !vp, ok_b});
    @(negedge clk);
    req_valid = 1'b0; op_done = 1'b1;
    tick();
    @(negedge clk);
    op_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 reset outputs", {a_perm, a_err, a_ep, a_ee, a_ev, a_abort, a_act,
                              b_perm, b_err, b_ep, b_ee, b_ev, b_abort, b_act}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R10 after release", {a_act, b_act, a_abort, b_abort}, '0);

    // R1 R2: page sweep, first and last byte of each 4 KiB page
    byte_mode = 1'b1;
    for (int k = 0; k < 256; k++) begin
      for (int e = 0; e < 2; e++) begin
        int a = k * 4096 + e * 4095;
        word_addr = 19'(a >> 1); byte_lsb = a[0];
        #2;
        check_map("R1 R2 map", a);
      end
    end

    // R3: word mode ignores byte_lsb, byte mode uses it
    for (int k = 0; k < 16; k++) begin
      int w = (k * 37123 + 4321) % 524288;
      word_addr = 19'(w); byte_lsb = 1'b1;
      byte_mode = 1'b0;
      #2;
      check_map("R3 word mode", 2 * w);
      byte_mode = 1'b1;
      #2;
      check_map("R3 byte mode", 2 * w + 1);
    end

    // R4 R5 R6 R7: decision table
    for (int s = 0; s < 4; s++) begin
      int a = (s == 0) ? 32'h01000 : (s == 1) ? 32'hFE000 : (s == 2) ? 32'h05000 : 32'h40000;
      for (int f = 0; f < 16; f++)
        req_chk(a, f[3], f[2], f[1], f[0]);
    end

    // R8: unlock loss aborts boot op only; supply loss aborts any op
    req_chk(32'h01000, 1'b0, 1'b1, 1'b0, 1'b1); // warm up, completed
    @(negedge clk);
    word_addr = 19'(32'h01000 >> 1); byte_lsb = 1'b0;
    wp_pin = 1'b1; hv_unlock = 1'b0; vpp_ok = 1'b1; req_erase = 1'b1; req_valid = 1'b1;
    tick();
    chk("R8 both started", {a_perm, a_act, b_perm, b_act}, 4'b1111);
    @(negedge clk);
    req_valid = 1'b0; wp_pin = 1'b0;
    tick();
    chk("R8 boot op aborted on unlock loss", {a_abort, a_act}, 2'b10);
    chk("R8 main op ignores unlock loss", {b_abort, b_act}, 2'b01);
    tick();
    chk("R8 abort is one cycle", {a_abort, b_abort, b_act}, 3'b001);
    @(negedge clk);
    vpp_ok = 1'b0;
    tick();
    chk("R8 main op aborted on supply loss", {b_abort, b_act}, 2'b10);
    tick();
    chk("R8 abort pulse ends", {a_abort, b_abort}, 2'b00);

    // R9: requests while busy are ignored, done ends op without abort
    @(negedge clk);
    vpp_ok = 1'b1; wp_pin = 1'b0; hv_unlock = 1'b0;
    word_addr = 19'(32'h40000 >> 1); req_erase = 1'b0; req_valid = 1'b1;
    tick();
    chk("R9 op started", {a_perm, a_act, b_perm, b_act}, 4'b1111);
    @(negedge clk);
    word_addr = 19'(32'h01000 >> 1); // boot block of bottom instance, locked
    tick();
    chk("R9 busy request ignored bottom", {a_perm, a_err, a_ep, a_ee, a_ev, a_act}, 6'b000001);
    chk("R9 busy request ignored top", {b_perm, b_err, b_act}, 3'b001);
    @(negedge clk);
    req_valid = 1'b0; op_done = 1'b1;
    tick();
    chk("R9 done clears op", {a_act, a_abort, b_act, b_abort}, 4'b0000);
    @(negedge clk);
    op_done = 1'b0;
    tick();
    chk("R9 idle after done", {a_act, a_abort, b_act, b_abort}, 4'b0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule